// File: doc/BRIEF.md
# Register Shift Unit

This block carries out the shift group of a 16-bit processor on one register operand. It can shift left, filling with zeros. It can shift right, filling with zeros or with copies of the sign bit. It can also rotate right. The surrounding datapath presents the operand, a 2-bit operation select, the 4-bit count field taken from the instruction, and the low four bits of register 0, together with a valid strobe.

One clock later the block returns the shifted word and five status flags. The flags are logical-greater, arithmetic-greater, equal, carry and overflow. The processor writes them into its status register.

The count rule follows the instruction set. A nonzero instruction field gives the shift distance directly. A zero field means the distance comes from register 0. If that nibble is also zero, the word is shifted by its full width of 16 positions.

Top module: `shift_unit`

## Requirements
- R1: A request with `in_valid` high at a rising edge produces `out_valid` high after that edge. `out_valid` is low after any edge with `in_valid` low, and the result and flags keep their values until the next request.
- R2: A nonzero `cnt_field` is the shift distance, and `r0_cnt` has no effect on the result.
- R3: When `cnt_field` is zero and `r0_cnt` is nonzero, `r0_cnt` is the shift distance.
- R4: When both `cnt_field` and `r0_cnt` are zero, the shift distance is 16.
- R5: `op` = 2'b10 shifts left and fills vacated low bits with zero.
- R6: `op` = 2'b01 shifts right and fills vacated high bits with zero.
- R7: `op` = 2'b00 shifts right and fills vacated high bits with copies of the original bit 15.
- R8: `op` = 2'b11 rotates right, so that bits leaving bit 0 re-enter at bit 15.
- R9: `flag_c` equals the last bit shifted out of the word. For the rotate, this is the bit that ends in bit 15.
- R10: For the left shift, `flag_ov` is set when bit 15 differs from its original value after any single step of the shift. `flag_ov` is clear for the other three operations.
- R11: `flag_eq` is set when the result is zero. `flag_lgt` is set when the result is nonzero. `flag_agt` is set when the result is nonzero with bit 15 clear.
- R12: After reset, `out_valid`, `result` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | 00 right arithmetic, 01 right logical, 10 left, 11 rotate right |
| operand | input | 16 | Word to shift |
| cnt_field | input | 4 | Count from the instruction, zero selects `r0_cnt` |
| r0_cnt | input | 4 | Low nibble of register 0 |
| out_valid | output | 1 | Result valid |
| result | output | 16 | Shifted word |
| flag_lgt | output | 1 | Logical greater than zero |
| flag_agt | output | 1 | Arithmetic greater than zero |
| flag_eq | output | 1 | Result equal to zero |
| flag_c | output | 1 | Last bit shifted out |
| flag_ov | output | 1 | Sign changed during the left shift |

## Verification
The bound checker watches several properties on every cycle:
- the one-cycle latency of the valid strobe, and the hold of the result between requests;
- the consistency of the three comparison flags with the result word;
- overflow staying clear outside the left shift;
- sign preservation on the arithmetic right shift;
- agreement between the rotate carry and the new bit 15.

Other behaviour needs the scoreboard scenarios, which compare every result against a step-by-step model:
- which count source is selected, including the distance of 16 when both sources are zero;
- the exact bit pattern of each operation;
- the carry value on the shifts;
- overflow raised by a sign that changes and then changes back.

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           op,
  input  logic [W-1:0]         operand,
  input  logic [$clog2(W)-1:0] cnt_field,
  input  logic [$clog2(W)-1:0] r0_cnt,
  output logic                 out_valid,
  output logic [W-1:0]         result,
  output logic                 flag_lgt,
  output logic                 flag_agt,
  output logic                 flag_eq,
  output logic                 flag_c,
  output logic                 flag_ov
);
  localparam int CW = $clog2(W);
  localparam logic [1:0] OP_SRA = 2'b00;
  localparam logic [1:0] OP_SRL = 2'b01;
  localparam logic [1:0] OP_SLA = 2'b10;
  localparam logic [1:0] OP_SRC = 2'b11;

  logic [CW:0]    amt;
  logic [CW-1:0]  lidx, ridx;
  logic [W:0]     ext, top, ones;
  logic [2*W-1:0] rot;
  logic [W-1:0]   shifted;
  logic           cout, ovf;

  assign amt = (cnt_field != '0) ? {1'b0, cnt_field}
             : (r0_cnt != '0)    ? {1'b0, r0_cnt}
             : (CW+1)'(W);

  assign lidx = CW'(W - int'(amt));
  assign ridx = CW'(int'(amt) - 1);
  assign ext  = {operand, 1'b0};
  assign top  = ext >> lidx;
  assign ones = ((W+1)'(1) << (int'(amt) + 1)) - (W+1)'(1);
  assign rot  = {operand, operand} >> amt;

  always_comb begin
    shifted = '0;
    cout    = 1'b0;
    ovf     = 1'b0;
    unique case (op)
      OP_SLA: begin
        shifted = operand << amt;
        cout    = operand[lidx];
        ovf     = !(top == '0 || top == ones);
      end
      OP_SRL: begin
        shifted = operand >> amt;
        cout    = operand[ridx];
      end
      OP_SRA: begin
        shifted = W'($signed(operand) >>> amt);
        cout    = operand[ridx];
      end
      default: begin
        shifted = rot[W-1:0];
        cout    = operand[ridx];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_lgt  <= 1'b0;
      flag_agt  <= 1'b0;
      flag_eq   <= 1'b0;
      flag_c    <= 1'b0;
      flag_ov   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= shifted;
        flag_lgt <= shifted != '0;
        flag_agt <= (shifted != '0) && !shifted[W-1];
        flag_eq  <= shifted == '0;
        flag_c   <= cout;
        flag_ov  <= ovf;
      end
    end
  end
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   op,
  input logic [W-1:0] operand,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         flag_lgt,
  input logic         flag_agt,
  input logic         flag_eq,
  input logic         flag_c,
  input logic         flag_ov
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(flag_c) && $stable(flag_ov));
  a_r11_eq_lgt: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_eq != flag_lgt) && (flag_eq == (result == '0)));
  a_r11_agt_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_agt) |-> (flag_lgt && !result[W-1]));
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 2'b10) |=> !flag_ov);
  a_r7_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b00) |=> result[W-1] == $past(operand[W-1]));
  a_r9_rotate_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b11) |=> flag_c == result[W-1]);
endmodule

bind shift_unit shift_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .operand(operand),
  .out_valid(out_valid), .result(result), .flag_lgt(flag_lgt),
  .flag_agt(flag_agt), .flag_eq(flag_eq), .flag_c(flag_c), .flag_ov(flag_ov)
);

// File: tb/tb_shift_unit.sv
`timescale 1ns/1ps
module tb_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0;
  logic [15:0] operand = '0;
  logic [3:0]  cnt_field = '0;
  logic [3:0]  r0_cnt = '0;
  logic        out_valid;
  logic [15:0] result;
  logic        flag_lgt, flag_agt, flag_eq, flag_c, flag_ov;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] res;
    logic [4:0]  flags;
    string       tag;
  } exp_t;
  exp_t sb[$];
  exp_t last;

  always #2 clk = ~clk;

  shift_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .operand(operand),
    .cnt_field(cnt_field), .r0_cnt(r0_cnt), .out_valid(out_valid),
    .result(result), .flag_lgt(flag_lgt), .flag_agt(flag_agt),
    .flag_eq(flag_eq), .flag_c(flag_c), .flag_ov(flag_ov)
  );

  function automatic exp_t model(logic [1:0] o, logic [15:0] v, logic [3:0] cf,
                                 logic [3:0] r0, string tag);
    exp_t e;
    int n;
    logic c, ov, s0;
    n = (cf != 0) ? int'(cf) : (r0 != 0) ? int'(r0) : 16;
    c = 0; ov = 0; s0 = v[15];
    for (int k = 0; k < n; k++) begin
      case (o)
        2'b10: begin c = v[15]; v = {v[14:0], 1'b0}; if (v[15] != s0) ov = 1; end
        2'b01: begin c = v[0]; v = {1'b0, v[15:1]}; end
        2'b00: begin c = v[0]; v = {v[15], v[15:1]}; end
        default: begin c = v[0]; v = {v[0], v[15:1]}; end
      endcase
    end
    e.res = v;
    e.flags = {v != 0, (v != 0) && !v[15], v == 0, c, ov};
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(logic [1:0] o, logic [15:0] v, logic [3:0] cf,
                       logic [3:0] r0, string tag);
    @(negedge clk);
    op = o; operand = v; cnt_field = cf; r0_cnt = r0; in_valid = 1'b1;
    sb.push_back(model(o, v, cf, r0, tag));
    last = sb[$];
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      operand = 16'hDEAD; cnt_field = 4'd3; r0_cnt = 4'd5; op = 2'b10;
    end
  endtask

  task automatic check(string tag, logic [20:0] act, logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      if (sb.size() == 0) check("R1 unexpected out_valid", 21'd1, 21'd0);
      else begin
        e = sb.pop_front();
        check(e.tag, {result, flag_lgt, flag_agt, flag_eq, flag_c, flag_ov},
              {e.res, e.flags});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset state",
          {result, flag_lgt, flag_agt, flag_eq, flag_c, flag_ov}, 21'd0);
    check("R12 reset valid", {20'd0, out_valid}, 21'd0);
    rst_n = 1'b1;
    drive(2'b10, 16'h1234, 4'd4, 4'd7, "R5 R2 left by field");
    drive(2'b01, 16'h8F01, 4'd3, 4'd9, "R6 R2 logical right");
    drive(2'b00, 16'h8F01, 4'd3, 4'd0, "R7 arithmetic right");
    drive(2'b11, 16'h0013, 4'd2, 4'd0, "R8 R9 rotate right");
    drive(2'b10, 16'h00F0, 4'd0, 4'd6, "R3 left by r0");
    drive(2'b00, 16'h7FFF, 4'd0, 4'd15, "R3 arithmetic by r0");
    drive(2'b10, 16'hABCD, 4'd0, 4'd0, "R4 left by 16");
    drive(2'b01, 16'hABCD, 4'd0, 4'd0, "R4 logical by 16");
    drive(2'b00, 16'hABCD, 4'd0, 4'd0, "R4 arithmetic by 16");
    drive(2'b11, 16'hABCD, 4'd0, 4'd0, "R4 rotate by 16");
    drive(2'b10, 16'h4000, 4'd1, 4'd0, "R10 overflow on sign change");
    drive(2'b10, 16'hC000, 4'd1, 4'd0, "R10 no overflow sign kept");
    drive(2'b10, 16'h2000, 4'd3, 4'd0, "R10 overflow sign back");
    drive(2'b01, 16'h8000, 4'd1, 4'd0, "R10 cleared on right shift");
    drive(2'b01, 16'h0001, 4'd1, 4'd0, "R11 R9 zero result carry");
    drive(2'b11, 16'h0001, 4'd1, 4'd0, "R11 negative rotate");
    drive(2'b00, 16'h0100, 4'd8, 4'd0, "R11 positive result");
    drive(2'b10, 16'h8001, 4'd15, 4'd2, "R9 left carry");
    idle(1);
    for (int i = 0; i < 24; i++) begin
      logic [15:0] v;
      v = 16'h9E37 * 16'(i + 1) ^ 16'(i << 5);
      drive(2'(i), v, 4'(i * 7), 4'(i * 3), "R2 R3 mixed sweep");
      if (i % 5 == 4) idle(2);
    end
    idle(4);
    check("R1 hold after idle",
          {result, flag_lgt, flag_agt, flag_eq, flag_c, flag_ov},
          {last.res, last.flags});
    check("R1 valid low when idle", {20'd0, out_valid}, 21'd0);
    check("R1 scoreboard drained", 21'(sb.size()), 21'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule